// File: doc/BRIEF.md
# Buffered Asynchronous Serial Port with Selectable Bit Clock

This block is a full-duplex asynchronous serial port carrying 8N1 frames. Bytes written into a 16-entry transmit queue leave one after another on `txd`, least-significant bit first. Frames arriving on `rxd` are reassembled and placed in a 16-entry receive queue. The receive queue shows its oldest entry on its output and advances on a read strobe.

All bit timing is derived from a 16x oversampling tick. The tick comes from one of two sources, chosen by a two-bit clock-source field:
- an internal down-counter, reloaded from an 8-bit divisor;
- the rising edges of an external clock, taken in through a synchronizer.

In one internal setting the internal 16x clock is also driven out on the serial-clock pin.

The transmit and receive enables behave differently from each other:
- Dropping the transmit enable releases the line at once and returns the transmit sequencer to idle.
- Queued bytes and status flags stay untouched when the transmit enable drops.
- A separate transmit-queue clear empties the transmit queue.

Top module: `uart16_serial`

## Requirements
- R1: After reset the transmit and receive queues are empty, `tx_end` is 1, `frame_err` and `overrun` are 0, and `txd_oe` and `sck_oe` are 0.
- R2: `txd_oe` equals `tx_en` in the same cycle, with no register on the way. While `tx_en` is 1 and no frame is in progress, `txd` is 1 (mark).
- R3: A frame is one start bit (0), eight data bits with bit 0 first, and one stop bit (1). Each bit lasts 16 ticks. With an internal source, one tick occurs every `divisor`+1 clock cycles.
- R4: A frame received while `rx_en` is 1 places its byte in the receive queue. `rx_data` shows the oldest entry while `rx_empty` is 0, and a one-cycle `rx_rd` removes it.
- R5: `tx_end` goes to 0 when the transmitter takes a byte from its queue. It goes to 1 when a stop bit finishes and the transmit queue is empty.
- R6: The transmit queue holds 16 bytes and raises `tx_full` when it holds 16. A `tx_wr` while it is full is ignored.
- R7: A frame that completes while the receive queue is full is discarded, sets `overrun`, and leaves the queued bytes unchanged. `overrun` stays set until reset.
- R8: Clearing `tx_en` in mid-frame has these effects:
  - it drops `txd_oe` in that cycle;
  - it abandons the frame, and no frame resumes when `tx_en` returns;
  - it keeps the transmit queue contents and `tx_end`.
- R9: A pulse of `tx_fifo_clr` empties the transmit queue.
- R10: A stop bit sampled as 0 sets `frame_err`, which stays set until reset. The byte is still stored.
- R11: While `rx_en` is 0, activity on `rxd` stores nothing.
- R12: `clk_sel` selects the tick source and the pin drive:
  - 00: internal source, pin not driven (`sck_oe`=0);
  - 01: internal source, pin driven, with `sck_out` running at one period per tick;
  - 10 or 11: external source, pin not driven.
- R13: With an external source, each rising edge of `sck_in` gives one tick, after a two-flop synchronizer. A frame then spans 160 `sck_in` periods.
- R14: `rxd` passes through a two-flop synchronizer. A start bit is confirmed only if the line is still low at the eighth tick after the falling edge is seen. A shorter low pulse is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| clk_sel | input | 2 | Tick source and pin-drive select |
| divisor | input | 8 | Internal tick reload value |
| tx_fifo_clr | input | 1 | Empties the transmit queue |
| tx_wr | input | 1 | Write strobe into the transmit queue |
| tx_data | input | 8 | Byte to enqueue |
| tx_full | output | 1 | Transmit queue holds 16 bytes |
| tx_empty | output | 1 | Transmit queue empty |
| tx_end | output | 1 | Last stop bit sent and queue empty |
| rx_rd | input | 1 | Removes the oldest received byte |
| rx_data | output | 8 | Oldest received byte |
| rx_full | output | 1 | Receive queue holds 16 bytes |
| rx_empty | output | 1 | Receive queue empty |
| frame_err | output | 1 | Sticky framing error |
| overrun | output | 1 | Sticky receive overrun |
| txd | output | 1 | Serial data out |
| txd_oe | output | 1 | Output enable for `txd` |
| rxd | input | 1 | Serial data in |
| sck_in | input | 1 | External 16x clock |
| sck_out | output | 1 | Internal 16x clock out |
| sck_oe | output | 1 | Output enable for `sck_out` |

## Verification
The assertions assume three things about the inputs:
- `tx_wr` is never raised together with `tx_fifo_clr`;
- `rx_rd` is only pulsed while a byte is queued;
- `clk_sel` and `divisor` are held steady while a frame is in flight, so each bit spans exactly 16 ticks.

The stimulus changes the clock source and divisor only when both directions are idle, and strobes reads only after checking `rx_empty`. With an external source it holds `sck_in` high and low for at least two system clocks each, so the synchronizer sees every edge.

// File: rtl/uart16_pkg.sv
package uart16_pkg;
    localparam int OVS       = 16;
    localparam int DATA_BITS = 8;
    localparam int SUB_W     = $clog2(OVS);
    localparam int BIT_W     = $clog2(DATA_BITS);

    typedef enum logic [1:0] {PH_IDLE, PH_START, PH_DATA, PH_STOP} phase_e;

    typedef struct packed {
        phase_e               ph;
        logic [SUB_W-1:0]     sub;
        logic [BIT_W-1:0]     bitn;
        logic [DATA_BITS-1:0] sh;
    } ser_st_t;

    localparam logic [1:0] CKS_INT_DRIVE = 2'b01;

    function automatic logic src_is_ext(input logic [1:0] sel);
        return sel[1];
    endfunction
endpackage

// File: rtl/uart16_tick.sv
module uart16_tick
    import uart16_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       clk_sel,
    input  logic [DIV_W-1:0] divisor,
    input  logic             sck_in,
    output logic             tick,
    output logic             sck_out,
    output logic             sck_oe
);
    localparam logic [DIV_W-1:0] ONE = 1;

    logic [DIV_W-1:0] cnt;
    logic [2:0]       ext_sync;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            ext_sync <= '0;
        end else begin
            cnt      <= (cnt == '0) ? divisor : cnt - ONE;
            ext_sync <= {ext_sync[1:0], sck_in};
        end
    end

    always_comb begin
        tick    = src_is_ext(clk_sel) ? (ext_sync[1] & ~ext_sync[2]) : (cnt == '0);
        sck_oe  = (clk_sel == CKS_INT_DRIVE);
        sck_out = sck_oe & (cnt > (divisor >> 1));
    end
endmodule

// File: rtl/uart16_fifo.sv
module uart16_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         wr,
    input  logic [W-1:0] din,
    input  logic         rd,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0]   CAP  = DEPTH[AW:0];
    localparam logic [AW-1:0] STEP = 1;
    localparam logic [AW:0]   UNIT = 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          do_wr, do_rd;

    assign full  = (cnt == CAP);
    assign empty = (cnt == '0);
    assign do_wr = wr & ~full;
    assign do_rd = rd & ~empty;
    assign dout  = mem[rp];

    always_ff @(posedge clk) begin
        if (do_wr && !clr) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) wp <= wp + STEP;
            if (do_rd) rp <= rp + STEP;
            case ({do_wr, do_rd})
                2'b10:   cnt <= cnt + UNIT;
                2'b01:   cnt <= cnt - UNIT;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/uart16_tx.sv
module uart16_tx
    import uart16_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 tick,
    input  logic                 q_empty,
    input  logic [DATA_BITS-1:0] q_data,
    input  logic                 q_clr,
    output logic                 pop,
    output logic                 txd,
    output logic                 txd_oe,
    output logic                 tx_end
);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_BITS - 1);

    ser_st_t st;

    assign pop    = en && (st.ph == PH_IDLE) && !q_empty && !q_clr;
    assign txd_oe = en;

    always_comb begin
        case (st.ph)
            PH_START: txd = 1'b0;
            PH_DATA:  txd = st.sh[0];
            default:  txd = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= '{ph: PH_IDLE, sub: '0, bitn: '0, sh: '1};
            tx_end <= 1'b1;
        end else if (!en) begin
            st.ph   <= PH_IDLE;
            st.sub  <= '0;
            st.bitn <= '0;
        end else if (st.ph == PH_IDLE) begin
            if (pop) begin
                st.ph  <= PH_START;
                st.sub <= '0;
                st.sh  <= q_data;
                tx_end <= 1'b0;
            end
        end else if (tick) begin
            st.sub <= st.sub + 1'b1;
            if (st.sub == SUB_LAST) begin
                case (st.ph)
                    PH_START: begin
                        st.ph   <= PH_DATA;
                        st.bitn <= '0;
                    end
                    PH_DATA: begin
                        st.sh   <= {1'b1, st.sh[DATA_BITS-1:1]};
                        st.bitn <= st.bitn + 1'b1;
                        if (st.bitn == BIT_LAST) st.ph <= PH_STOP;
                    end
                    default: begin
                        st.ph <= PH_IDLE;
                        if (q_empty) tx_end <= 1'b1;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/uart16_rx.sv
module uart16_rx
    import uart16_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 tick,
    input  logic                 rxd,
    input  logic                 q_full,
    output logic                 push,
    output logic [DATA_BITS-1:0] pdata,
    output logic                 frame_err,
    output logic                 overrun
);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
    localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OVS / 2 - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_BITS - 1);

    ser_st_t    st;
    logic [1:0] sync;
    logic       line;
    logic       stop_pt;

    assign line    = sync[1];
    assign stop_pt = en && (st.ph == PH_STOP) && tick && (st.sub == SUB_LAST);
    assign push    = stop_pt && !q_full;
    assign pdata   = st.sh;

    always_ff @(posedge clk) begin
        if (rst) sync <= 2'b11;
        else     sync <= {sync[0], rxd};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= '{ph: PH_IDLE, sub: '0, bitn: '0, sh: '0};
            frame_err <= 1'b0;
            overrun   <= 1'b0;
        end else if (!en) begin
            st.ph  <= PH_IDLE;
            st.sub <= '0;
        end else if (tick) begin
            case (st.ph)
                PH_IDLE: if (!line) begin
                    st.ph  <= PH_START;
                    st.sub <= '0;
                end
                PH_START: begin
                    st.sub <= st.sub + 1'b1;
                    if (st.sub == SUB_MID) begin
                        st.sub  <= '0;
                        st.bitn <= '0;
                        st.ph   <= line ? PH_IDLE : PH_DATA;
                    end
                end
                PH_DATA: begin
                    st.sub <= st.sub + 1'b1;
                    if (st.sub == SUB_LAST) begin
                        st.sh   <= {line, st.sh[DATA_BITS-1:1]};
                        st.bitn <= st.bitn + 1'b1;
                        if (st.bitn == BIT_LAST) st.ph <= PH_STOP;
                    end
                end
                default: begin
                    st.sub <= st.sub + 1'b1;
                    if (stop_pt) begin
                        st.ph <= PH_IDLE;
                        if (!line)  frame_err <= 1'b1;
                        if (q_full) overrun   <= 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/uart16_serial.sv
module uart16_serial
    import uart16_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int Q_DEPTH = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tx_en,
    input  logic                 rx_en,
    input  logic [1:0]           clk_sel,
    input  logic [DIV_W-1:0]     divisor,
    input  logic                 tx_fifo_clr,
    input  logic                 tx_wr,
    input  logic [DATA_BITS-1:0] tx_data,
    output logic                 tx_full,
    output logic                 tx_empty,
    output logic                 tx_end,
    input  logic                 rx_rd,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_full,
    output logic                 rx_empty,
    output logic                 frame_err,
    output logic                 overrun,
    output logic                 txd,
    output logic                 txd_oe,
    input  logic                 rxd,
    input  logic                 sck_in,
    output logic                 sck_out,
    output logic                 sck_oe
);
    logic                 tick;
    logic                 tx_pop;
    logic [DATA_BITS-1:0] tx_head;
    logic                 rx_push;
    logic [DATA_BITS-1:0] rx_byte;

    uart16_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst(rst), .clk_sel(clk_sel), .divisor(divisor),
        .sck_in(sck_in), .tick(tick), .sck_out(sck_out), .sck_oe(sck_oe)
    );

    uart16_fifo #(.W(DATA_BITS), .DEPTH(Q_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .clr(tx_fifo_clr), .wr(tx_wr), .din(tx_data),
        .rd(tx_pop), .dout(tx_head), .full(tx_full), .empty(tx_empty)
    );

    uart16_tx u_tx (
        .clk(clk), .rst(rst), .en(tx_en), .tick(tick), .q_empty(tx_empty),
        .q_data(tx_head), .q_clr(tx_fifo_clr), .pop(tx_pop), .txd(txd),
        .txd_oe(txd_oe), .tx_end(tx_end)
    );

    uart16_rx u_rx (
        .clk(clk), .rst(rst), .en(rx_en), .tick(tick), .rxd(rxd),
        .q_full(rx_full), .push(rx_push), .pdata(rx_byte),
        .frame_err(frame_err), .overrun(overrun)
    );

    uart16_fifo #(.W(DATA_BITS), .DEPTH(Q_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .clr(1'b0), .wr(rx_push), .din(rx_byte),
        .rd(rx_rd), .dout(rx_data), .full(rx_full), .empty(rx_empty)
    );
endmodule

// File: rtl/uart16_serial_chk.sv
module uart16_serial_chk (
    input logic       clk,
    input logic       rst,
    input logic       tx_en,
    input logic       rx_en,
    input logic [1:0] clk_sel,
    input logic       tx_fifo_clr,
    input logic       tx_wr,
    input logic       tx_full,
    input logic       tx_empty,
    input logic       tx_end,
    input logic       rx_rd,
    input logic       rx_full,
    input logic       rx_empty,
    input logic       frame_err,
    input logic       overrun,
    input logic       txd,
    input logic       sck_oe
);
    AST_IDLE_MARK: assert property (@(posedge clk) disable iff (rst)
        tx_en && tx_end |-> txd); // R2

    AST_TXQ_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(tx_full && tx_empty)); // R6

    AST_RXQ_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rx_full && rx_empty)); // R4

    AST_FULL_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
        tx_full && tx_wr && !tx_en && !tx_fifo_clr |=> tx_full); // R6

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun); // R7

    AST_FERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> frame_err); // R10

    AST_RX_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rx_en && !rx_rd && rx_empty |=> rx_empty); // R11

    AST_TEND_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_end) |-> tx_empty); // R5

    AST_EXT_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        clk_sel[1] |-> !sck_oe); // R12
endmodule

bind uart16_serial uart16_serial_chk u_chk (
    .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en), .clk_sel(clk_sel),
    .tx_fifo_clr(tx_fifo_clr), .tx_wr(tx_wr), .tx_full(tx_full),
    .tx_empty(tx_empty), .tx_end(tx_end), .rx_rd(rx_rd), .rx_full(rx_full),
    .rx_empty(rx_empty), .frame_err(frame_err), .overrun(overrun),
    .txd(txd), .sck_oe(sck_oe)
);

// File: tb/uart16_serial_bench.sv
module uart16_serial_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    localparam logic [15:0] VEC [NVEC] = '{
        {8'h55, 8'h55}, {8'hA3, 8'hA3}, {8'h00, 8'h00},
        {8'hFF, 8'hFF}, {8'h01, 8'h01}, {8'h80, 8'h80}
    };

    logic clk = 0, rst = 1;
    logic tx_en = 0, rx_en = 0, tx_fifo_clr = 0, tx_wr = 0, rx_rd = 0;
    logic [1:0] clk_sel = 2'b00;
    logic [7:0] divisor = 8'd0, tx_data = 8'd0, rx_data;
    logic tx_full, tx_empty, tx_end, rx_full, rx_empty, frame_err, overrun;
    logic txd, txd_oe, rxd, sck_out, sck_oe;
    logic sck_in = 0, ext_run = 0, loop_on = 0, rxd_drv = 1;
    logic te_mid, done = 0;
    int nchk = 0, nbad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign rxd = loop_on ? (txd_oe ? txd : 1'b1) : rxd_drv;

    always begin
        repeat (2) @(posedge clk);
        if (ext_run) sck_in = ~sck_in;
    end

    uart16_serial u_uart16_serial (
        .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en), .clk_sel(clk_sel),
        .divisor(divisor), .tx_fifo_clr(tx_fifo_clr), .tx_wr(tx_wr),
        .tx_data(tx_data), .tx_full(tx_full), .tx_empty(tx_empty),
        .tx_end(tx_end), .rx_rd(rx_rd), .rx_data(rx_data), .rx_full(rx_full),
        .rx_empty(rx_empty), .frame_err(frame_err), .overrun(overrun),
        .txd(txd), .txd_oe(txd_oe), .rxd(rxd), .sck_in(sck_in),
        .sck_out(sck_out), .sck_oe(sck_oe)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1; tx_en = 0; rx_en = 0; loop_on = 0; rxd_drv = 1;
        ext_run = 0; clk_sel = 2'b00; divisor = 8'd0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
    endtask

    task automatic wr_tx(input logic [7:0] b);
        @(negedge clk); tx_wr = 1; tx_data = b;
        @(negedge clk); tx_wr = 0;
    endtask

    task automatic pop_rx();
        @(negedge clk); rx_rd = 1;
        @(negedge clk); rx_rd = 0;
    endtask

    task automatic cap_frame(input int bitc, output logic [7:0] b,
                             output logic stop_v, output logic found);
        found = 0; b = 8'h0; stop_v = 0;
        for (int t = 0; t < 20000 && !found; t++) begin
            @(negedge clk);
            if (txd === 1'b0) found = 1;
        end
        if (found) begin
            repeat (bitc/2) @(negedge clk);
            te_mid = tx_end;
            if (txd !== 1'b0) found = 0;
            for (int i = 0; i < 8; i++) begin
                repeat (bitc) @(negedge clk);
                b[i] = txd;
            end
            repeat (bitc) @(negedge clk);
            stop_v = txd;
        end
    endtask

    task automatic wait_rx(input int lim, output logic got);
        got = 0;
        for (int t = 0; t < lim && !got; t++) begin
            @(negedge clk);
            if (!rx_empty) got = 1;
        end
    endtask

    task automatic send_rx(input logic [7:0] b, input logic stop_v, input int bitc);
        @(negedge clk); rxd_drv = 0;
        repeat (bitc) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd_drv = b[i];
            repeat (bitc) @(negedge clk);
        end
        rxd_drv = stop_v;
        repeat (bitc) @(negedge clk);
        rxd_drv = 1;
        repeat (bitc) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nbad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        logic sv, fnd, got;
        int cnt;

        do_reset();
        // R1 reset state
        chk(tx_empty && rx_empty && !tx_full && !rx_full, "R1 queues", {tx_empty, rx_empty}, 2'b11);
        chk(tx_end === 1'b1, "R1 tx_end", tx_end, 1);
        chk(!frame_err && !overrun, "R1 flags", {frame_err, overrun}, 0);
        chk(!txd_oe && !sck_oe, "R1 drives", {txd_oe, sck_oe}, 0);

        // R2 enable gives mark and output enable at once
        tx_en = 1; #1;
        chk(txd_oe === 1'b1, "R2 oe", txd_oe, 1);
        @(negedge clk);
        chk(txd === 1'b1, "R2 mark", txd, 1);
        chk(sck_oe === 1'b0, "R12 mode00 no drive", sck_oe, 0);

        // vector table: loopback, R3 frame, R4 receive, R5 tx_end
        rx_en = 1; loop_on = 1;
        for (int v = 0; v < NVEC; v++) begin
            wr_tx(VEC[v][15:8]);
            cap_frame(16, b, sv, fnd);
            chk(fnd && b == VEC[v][7:0] && sv, "R3 frame bits", b, VEC[v][7:0]);
            chk(te_mid === 1'b0, "R5 tx_end low in frame", te_mid, 0);
            wait_rx(200, got);
            chk(got && rx_data == VEC[v][7:0], "R4 rx byte", rx_data, VEC[v][7:0]);
            pop_rx();
            repeat (20) @(negedge clk);
            chk(tx_end === 1'b1, "R5 tx_end after stop", tx_end, 1);
            chk(rx_empty === 1'b1, "R4 rx popped", rx_empty, 1);
        end

        // R3 divisor 2 stretches each bit to 48 cycles
        divisor = 8'd2;
        wr_tx(8'h96);
        cap_frame(48, b, sv, fnd);
        chk(fnd && b == 8'h96 && sv, "R3 divisor rate", b, 8'h96);
        wait_rx(400, got);
        chk(got && rx_data == 8'h96, "R4 rx at divisor 2", rx_data, 8'h96);
        pop_rx();
        divisor = 8'd0;
        repeat (60) @(negedge clk);

        // R6 fill queue with tx disabled, one extra write ignored
        tx_en = 0;
        for (int i = 0; i < 17; i++) wr_tx(8'h10 + 8'(i));
        chk(tx_full === 1'b1, "R6 tx_full", tx_full, 1);
        tx_en = 1;
        got = 0;
        for (int t = 0; t < 6000 && !got; t++) begin
            @(negedge clk);
            if (rx_full) got = 1;
        end
        chk(got, "R7 rx queue filled", got, 1);
        repeat (30) @(negedge clk);
        chk(overrun === 1'b0, "R7 no overrun yet", overrun, 0);
        chk(tx_empty === 1'b1, "R6 extra byte not queued", tx_empty, 1);
        wr_tx(8'hEE);
        repeat (220) @(negedge clk);
        chk(overrun === 1'b1, "R7 overrun set", overrun, 1);
        for (int i = 0; i < 16; i++) begin
            chk(rx_data == 8'h10 + 8'(i), "R7 R6 queued order", rx_data, 8'h10 + i);
            pop_rx();
        end
        chk(rx_empty === 1'b1, "R7 dropped byte absent", rx_empty, 1);

        // R8 clear tx_en mid-frame, R9 queue clear
        rx_en = 0;
        wr_tx(8'hA1); wr_tx(8'hA2); wr_tx(8'hA3);
        fnd = 0;
        for (int t = 0; t < 500 && !fnd; t++) begin
            @(negedge clk);
            if (txd === 1'b0) fnd = 1;
        end
        repeat (20) @(negedge clk);
        tx_en = 0; #1;
        chk(txd_oe === 1'b0, "R8 oe drops at once", txd_oe, 0);
        @(negedge clk);
        chk(tx_empty === 1'b0, "R8 queue kept", tx_empty, 0);
        chk(tx_end === 1'b0, "R8 tx_end kept", tx_end, 0);
        @(negedge clk); tx_fifo_clr = 1;
        @(negedge clk); tx_fifo_clr = 0;
        chk(tx_empty === 1'b1, "R9 queue cleared", tx_empty, 1);
        tx_en = 1;
        cnt = 0;
        for (int t = 0; t < 60; t++) begin
            @(negedge clk);
            if (txd !== 1'b1) cnt++;
        end
        chk(cnt == 0, "R8 no frame resumes", cnt, 0);

        // R10 framing error
        do_reset();
        rx_en = 1;
        send_rx(8'h3C, 1'b0, 16);
        chk(!rx_empty && rx_data == 8'h3C, "R10 byte kept", rx_data, 8'h3C);
        chk(frame_err === 1'b1, "R10 frame_err", frame_err, 1);
        pop_rx();

        // R11 disabled receiver stores nothing
        rx_en = 0;
        send_rx(8'h5A, 1'b1, 16);
        repeat (10) @(negedge clk);
        chk(rx_empty === 1'b1, "R11 rx off ignored", rx_empty, 1);

        // R14 short low pulse is not a start bit
        rx_en = 1;
        repeat (5) @(negedge clk);
        rxd_drv = 0;
        repeat (4) @(negedge clk);
        rxd_drv = 1;
        repeat (300) @(negedge clk);
        chk(rx_empty === 1'b1, "R14 glitch rejected", rx_empty, 1);

        // R12 clock output in mode 01
        clk_sel = 2'b01; divisor = 8'd3;
        @(negedge clk);
        chk(sck_oe === 1'b1, "R12 mode01 drive", sck_oe, 1);
        cnt = 0; sv = sck_out;
        for (int t = 0; t < 40; t++) begin
            @(negedge clk);
            if (sck_out && !sv) cnt++;
            sv = sck_out;
        end
        chk(cnt == 10, "R12 sck period", cnt, 10);
        clk_sel = 2'b10; #1;
        chk(sck_oe === 1'b0, "R12 mode10 no drive", sck_oe, 0);

        // R13 external 16x clock, 4-cycle period gives 64-cycle bits
        do_reset();
        clk_sel = 2'b10; ext_run = 1;
        tx_en = 1; rx_en = 1; loop_on = 1;
        repeat (20) @(negedge clk);
        wr_tx(8'hC6);
        cap_frame(64, b, sv, fnd);
        chk(fnd && b == 8'hC6 && sv, "R13 ext frame", b, 8'hC6);
        wait_rx(800, got);
        chk(got && rx_data == 8'hC6, "R13 ext receive", rx_data, 8'hC6);

        done = 1;
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule